// File: doc/BRIEF.md
# Chained Transmit Command Sequencer

This block walks a ring of transmit command blocks that sit in a small on-block memory. Each block is one control word and one status word. The control word holds a suspend flag, an interrupt flag and the index of the next block. The sequencer fetches a block and models the frame transmission as a fixed-latency wait. It then marks the block done in its status word and either moves on to the linked block or stops in a suspended state. While the unit runs, the host appends work by preparing a new block and clearing the suspend flag of the block before it. It then issues a resume command.

A one-entry command register accepts a start strobe, with a block index, or a resume strobe. The register shows the command for one cycle and then returns to zero, and the host waits for zero before issuing the next strobe. When the unit suspends, it keeps the link of the last executed block. On resume it re-reads only that block's suspend flag. If the flag is still set, the resume has no effect. If it is clear, execution continues at the kept link, and the link is not read from memory again. A configuration input selects the interrupt source. In suspend-entry mode, every entry into suspension raises a one-cycle pulse. In per-block mode, a pulse follows each finished block that carries the interrupt flag.

Top module: `txcu_top`

## Requirements
- R1: The command register (`cmd_pend`, code 0 none, 1 start, 2 resume) latches a strobe only while it reads 0. It shows the code for exactly one cycle and then reads 0. A strobe that arrives while the register is non-zero is dropped. When both strobes arrive in the same cycle, start wins.
- R2: A start command from idle begins execution at the block given by `start_idx`. A start command in any other state has no effect.
- R3: Control word layout: bit 15 is suspend, bit 14 is interrupt, bits 7:0 are the next-block index. A finished block's status word is written as 16'h0001, with bit 0 meaning done. On the host port, address bit 0 selects the status word (1) or the control word (0), and bits 8:1 select the block.
- R4: A fetched block takes XMIT_LAT cycles to transmit and is then marked done. If its suspend bit is clear, the unit fetches the block at its link, and each block occupies XMIT_LAT+3 cycles.
- R5: After a block whose suspend bit is set, the unit enters suspension and executes no further block until a resume succeeds.
- R6: On a resume, if the last executed block's suspend bit still reads set, the unit stays suspended, executes nothing and raises no interrupt.
- R7: On a resume whose re-read suspend bit is clear, execution continues at the link that was saved when the unit suspended, even if the block's link in memory has since changed.
- R8: With `cfg_irq_mode`=0, `irq_o` pulses for one cycle on each entry into suspension and never on block completion.
- R9: With `cfg_irq_mode`=1, `irq_o` pulses for one cycle after each finished block whose interrupt bit is set, and never on suspension.
- R10: A host read returns data one cycle after the address. A write in the same cycle is not yet visible to that read.
- R11: After reset, the unit is idle, `cmd_pend` and `irq_o` are 0, and every memory word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_irq_mode | input | 1 | 0: interrupt on suspend entry, 1: interrupt per flagged block |
| start_stb | input | 1 | Start command strobe |
| start_idx | input | 8 | First block index for a start |
| resume_stb | input | 1 | Resume command strobe |
| cmd_pend | output | 2 | Command register value |
| host_we | input | 1 | Host write enable |
| host_addr | input | 9 | Host word address {block, select} |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle latency |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is a resume whose outcome depends on the kept link and not on memory. While the unit is suspended, the bench rewrites the control word of the last executed block so that its suspend bit is clear and its link points to a different block. It then checks which block's status word turns done. The bench also issues resumes while the suspend bit is still set and strobes back-to-back or simultaneously, to show that nothing moves. It repeats the chain in both interrupt modes against a per-cycle reference model.

// File: rtl/txcu_pkg.sv
package txcu_pkg;
    localparam int WORD_W   = 16;
    localparam int LINK_W   = 8;
    localparam int NUM_BLK  = 1 << LINK_W;
    localparam int HADDR_W  = LINK_W + 1;
    localparam logic [WORD_W-1:0] DONE_WORD = 16'h0001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_WBACK,
        ST_CHKS,
        ST_SUSP,
        ST_RCHK
    } cu_state_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_START  = 2'd1,
        CMD_RESUME = 2'd2
    } cu_cmd_e;

    typedef struct packed {
        logic              susp;
        logic              irq;
        logic [5:0]        spare;
        logic [LINK_W-1:0] link;
    } blk_word_t;

    function automatic blk_word_t to_blk(input logic [WORD_W-1:0] w);
        return blk_word_t'(w);
    endfunction
endpackage

// File: rtl/txcu_blkmem.sv
module txcu_blkmem
    import txcu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    input  logic               cu_re,
    input  logic [LINK_W-1:0]  cu_raddr,
    output logic [WORD_W-1:0]  cu_rdata,
    input  logic               cu_we,
    input  logic [LINK_W-1:0]  cu_waddr
);
    logic [WORD_W-1:0] ctl_mem [NUM_BLK];
    logic [WORD_W-1:0] st_mem  [NUM_BLK];
    logic [LINK_W-1:0] hblk;

    assign hblk = host_addr[HADDR_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BLK; i++) begin
                ctl_mem[i] <= '0;
                st_mem[i]  <= '0;
            end
            host_rdata <= '0;
            cu_rdata   <= '0;
        end else begin
            host_rdata <= host_addr[0] ? st_mem[hblk] : ctl_mem[hblk];
            if (cu_re)
                cu_rdata <= ctl_mem[cu_raddr];
            if (host_we) begin
                if (host_addr[0])
                    st_mem[hblk] <= host_wdata;
                else
                    ctl_mem[hblk] <= host_wdata;
            end
            if (cu_we)
                st_mem[cu_waddr] <= DONE_WORD;
        end
    end
endmodule

// File: rtl/txcu_xmit_timer.sv
module txcu_xmit_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic done
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (go)
            cnt_q <= CNT_W'(LAT);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == CNT_W'(1));

    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        go |-> cnt_q == '0); // R4
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done && !go |=> cnt_q == '0); // R4
endmodule

// File: rtl/txcu_seq.sv
module txcu_seq
    import txcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_irq_mode,
    input  logic              start_stb,
    input  logic [LINK_W-1:0] start_idx,
    input  logic              resume_stb,
    output logic [1:0]        cmd_pend,
    output logic              rd_en,
    output logic [LINK_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [LINK_W-1:0] wr_addr,
    output logic              xmit_go,
    input  logic              xmit_done,
    output logic              irq_o
);
    cu_state_e         state_q;
    cu_cmd_e           cmd_q;
    logic [LINK_W-1:0] cur_q;
    logic [LINK_W-1:0] link_q;
    logic [LINK_W-1:0] sidx_q;
    logic              irq_q;
    blk_word_t         blk;

    assign blk      = to_blk(rd_data);
    assign cmd_pend = cmd_q;
    assign irq_o    = irq_q;
    assign rd_addr  = cur_q;
    assign wr_addr  = cur_q;
    assign wr_en    = (state_q == ST_WBACK);
    assign xmit_go  = (state_q == ST_FETCH);
    assign rd_en    = (state_q == ST_FETCH) ||
                      (state_q == ST_SUSP && cmd_q == CMD_RESUME);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NONE;
            cur_q   <= '0;
            link_q  <= '0;
            sidx_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (cmd_q != CMD_NONE) begin
                cmd_q <= CMD_NONE;
            end else if (start_stb) begin
                cmd_q  <= CMD_START;
                sidx_q <= start_idx;
            end else if (resume_stb) begin
                cmd_q <= CMD_RESUME;
            end

            case (state_q)
                ST_IDLE: begin
                    if (cmd_q == CMD_START) begin
                        cur_q   <= sidx_q;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_EXEC;
                ST_EXEC: begin
                    if (xmit_done)
                        state_q <= ST_WBACK;
                end
                ST_WBACK: begin
                    link_q <= blk.link;
                    if (cfg_irq_mode && blk.irq)
                        irq_q <= 1'b1;
                    state_q <= ST_CHKS;
                end
                ST_CHKS: begin
                    if (blk.susp) begin
                        state_q <= ST_SUSP;
                        if (!cfg_irq_mode)
                            irq_q <= 1'b1;
                    end else begin
                        cur_q   <= link_q;
                        state_q <= ST_FETCH;
                    end
                end
                ST_SUSP: begin
                    if (cmd_q == CMD_RESUME)
                        state_q <= ST_RCHK;
                end
                ST_RCHK: begin
                    if (blk.susp) begin
                        state_q <= ST_SUSP;
                    end else begin
                        cur_q   <= link_q;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_q != CMD_NONE |=> cmd_q == CMD_NONE); // R1
    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE && cmd_q == CMD_START |=> state_q == ST_FETCH && cur_q == $past(sidx_q)); // R2
    AST_SUSP_ON_FLAG: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_CHKS && blk.susp |=> state_q == ST_SUSP); // R5
    AST_RESUME_HOLDS: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_RCHK && blk.susp |=> state_q == ST_SUSP && !irq_q); // R6
    AST_SAVED_LINK: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_RCHK && !blk.susp |=> state_q == ST_FETCH && cur_q == $past(link_q)); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(state_q) == ST_CHKS && !$past(cfg_irq_mode)) ||
                  ($past(state_q) == ST_WBACK && $past(cfg_irq_mode))); // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q); // R9
endmodule

// File: rtl/txcu_top.sv
module txcu_top
    import txcu_pkg::*;
#(
    parameter int XMIT_LAT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_irq_mode,
    input  logic               start_stb,
    input  logic [LINK_W-1:0]  start_idx,
    input  logic               resume_stb,
    output logic [1:0]         cmd_pend,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    output logic               irq_o
);
    logic              rd_en;
    logic [LINK_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              wr_en;
    logic [LINK_W-1:0] wr_addr;
    logic              xmit_go;
    logic              xmit_done;

    txcu_blkmem mem_i (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cu_re      (rd_en),
        .cu_raddr   (rd_addr),
        .cu_rdata   (rd_data),
        .cu_we      (wr_en),
        .cu_waddr   (wr_addr)
    );

    txcu_xmit_timer #(.LAT(XMIT_LAT)) tmr_i (
        .clk  (clk),
        .rst  (rst),
        .go   (xmit_go),
        .done (xmit_done)
    );

    txcu_seq seq_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_irq_mode (cfg_irq_mode),
        .start_stb    (start_stb),
        .start_idx    (start_idx),
        .resume_stb   (resume_stb),
        .cmd_pend     (cmd_pend),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .xmit_go      (xmit_go),
        .xmit_done    (xmit_done),
        .irq_o        (irq_o)
    );
endmodule

// File: tb/txcu_top_tb_top.sv
module txcu_top_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_irq_mode = 1'b0;
    logic        start_stb = 1'b0;
    logic [7:0]  start_idx = '0;
    logic        resume_stb = 1'b0;
    logic [1:0]  cmd_pend;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    txcu_top #(.XMIT_LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .cfg_irq_mode(cfg_irq_mode),
        .start_stb(start_stb), .start_idx(start_idx), .resume_stb(resume_stb),
        .cmd_pend(cmd_pend), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_o(irq_o)
    );

    // behavioural reference: phases 0 idle,1 fetch,2 xmit,3 mark,4 decide,5 parked,6 recheck
    int m_ctl [256];
    int m_st  [256];
    int m_ph, m_cur, m_link, m_rd, m_left, m_cmd, m_sidx, m_irq, m_hrd;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_ctl[i]) begin m_ctl[i] = 0; m_st[i] = 0; end
            m_ph = 0; m_cur = 0; m_link = 0; m_rd = 0; m_left = 0;
            m_cmd = 0; m_sidx = 0; m_irq = 0; m_hrd = 0;
        end else begin
            int hb, n_hrd, n_cmd, n_irq, wb;
            hb = int'(host_addr[8:1]);
            n_hrd = host_addr[0] ? m_st[hb] : m_ctl[hb];
            n_irq = 0;
            wb = -1;
            case (m_ph)
                0: if (m_cmd == 1) begin m_cur = m_sidx; m_ph = 1; end
                1: begin m_rd = m_ctl[m_cur]; m_left = LAT; m_ph = 2; end
                2: if (m_left == 1) m_ph = 3; else m_left--;
                3: begin
                    wb = m_cur;
                    m_link = m_rd & 255;
                    if (cfg_irq_mode && m_rd[14]) n_irq = 1;
                    m_ph = 4;
                end
                4: if (m_rd[15]) begin m_ph = 5; if (!cfg_irq_mode) n_irq = 1; end
                   else begin m_cur = m_link; m_ph = 1; end
                5: if (m_cmd == 2) begin m_rd = m_ctl[m_cur]; m_ph = 6; end
                6: if (m_rd[15]) m_ph = 5;
                   else begin m_cur = m_link; m_ph = 1; end
                default: m_ph = 0;
            endcase
            if (m_cmd != 0) n_cmd = 0;
            else if (start_stb) begin n_cmd = 1; m_sidx = int'(start_idx); end
            else if (resume_stb) n_cmd = 2;
            else n_cmd = 0;
            if (host_we) begin
                if (host_addr[0]) m_st[hb] = int'(host_wdata);
                else m_ctl[hb] = int'(host_wdata);
            end
            if (wb >= 0) m_st[wb] = 1;
            m_hrd = n_hrd;
            m_cmd = n_cmd;
            m_irq = n_irq;
        end
    end

    always @(posedge clk) if (!rst && irq_o) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !ended) begin
            chk(cfg_irq_mode ? "R9 irq per cycle" : "R8 irq per cycle", int'(irq_o), m_irq);
            chk("R1 cmd_pend per cycle", int'(cmd_pend), m_cmd);
            chk("R10 host_rdata per cycle", int'(host_rdata), m_hrd);
        end
    end

    function automatic logic [15:0] mk(input bit s, input bit i, input int lnk);
        return {s, i, 6'b0, 8'(lnk)};
    endfunction

    task automatic wr(input int blk, input bit st, input logic [15:0] d);
        host_we = 1'b1; host_addr = {8'(blk), st}; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input int blk, input bit st, output int v);
        host_addr = {8'(blk), st};
        @(negedge clk);
        v = int'(host_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic resume_cmd();
        resume_stb = 1'b1;
        @(negedge clk);
        resume_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int v, c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 cmd_pend after reset", int'(cmd_pend), 0);
        chk("R11 irq after reset", int'(irq_o), 0);
        rd(5, 1'b0, v); chk("R11 memory zero", v, 0);

        // R10: write and read same word in one cycle, old value first
        wr(9, 1'b0, 16'h1234);
        chk("R10 read before write visible", int'(host_rdata), 0);
        idle(1);
        chk("R10 read after write", int'(host_rdata), 'h1234);

        // ring 0->1->2->3, block 3 suspends
        wr(0, 1'b0, mk(0, 0, 1));
        wr(1, 1'b0, mk(0, 0, 2));
        wr(2, 1'b0, mk(0, 0, 3));
        wr(3, 1'b0, mk(1, 0, 0));
        start_idx = 8'd0;
        start_stb = 1'b1;
        @(negedge clk);
        start_stb = 1'b0;
        chk("R1 start code shown", int'(cmd_pend), 1);
        idle(1);
        chk("R1 cmd clears", int'(cmd_pend), 0);
        idle(2 + 2 * (LAT + 3));
        rd(1, 1'b1, v); chk("R4 block 1 done mid-chain", v, 1);
        rd(3, 1'b1, v); chk("R4 block 3 not yet done", v, 0);
        idle(40);
        for (int b = 0; b < 4; b++) begin
            rd(b, 1'b1, v); chk("R3 done word 0001", v, 1);
        end
        chk("R8 one irq on suspend", irq_cnt, 1);

        // R5: parked, block 0 not re-run
        wr(0, 1'b1, 16'h0000);
        idle(30);
        rd(0, 1'b1, v); chk("R5 no execution while suspended", v, 0);

        // R6: resume with suspend bit still set
        c0 = irq_cnt;
        resume_cmd();
        chk("R1 resume code shown", int'(cmd_pend), 2);
        idle(30);
        rd(0, 1'b1, v); chk("R6 resume ignored, block 0 idle", v, 0);
        chk("R6 no irq on ignored resume", irq_cnt, c0);

        // R7: clear suspend on block 3 but point its link elsewhere
        wr(0, 1'b0, mk(1, 0, 1));
        wr(3, 1'b0, mk(0, 0, 5));
        resume_cmd();
        idle(40);
        rd(0, 1'b1, v); chk("R7 saved link block 0 ran", v, 1);
        rd(5, 1'b1, v); chk("R7 memory link block 5 unused", v, 0);
        chk("R8 irq on second suspend", irq_cnt, c0 + 1);

        // R9: per-block mode
        cfg_irq_mode = 1'b1;
        wr(1, 1'b0, mk(0, 1, 2));
        wr(2, 1'b0, mk(1, 1, 3));
        wr(1, 1'b1, 16'h0000);
        wr(2, 1'b1, 16'h0000);
        wr(0, 1'b0, mk(0, 0, 1));
        c0 = irq_cnt;
        resume_cmd();
        idle(50);
        rd(1, 1'b1, v); chk("R9 block 1 ran", v, 1);
        rd(2, 1'b1, v); chk("R9 block 2 ran", v, 1);
        chk("R9 two irqs, none on suspend", irq_cnt, c0 + 2);

        // R1: back-to-back strobes, second dropped
        resume_stb = 1'b1;
        @(negedge clk);
        chk("R1 first accepted", int'(cmd_pend), 2);
        @(negedge clk);
        resume_stb = 1'b0;
        chk("R1 second dropped", int'(cmd_pend), 0);

        // R1 priority and R2 start ignored when not idle
        wr(7, 1'b0, mk(1, 0, 7));
        start_idx = 8'd7;
        start_stb = 1'b1; resume_stb = 1'b1;
        @(negedge clk);
        start_stb = 1'b0; resume_stb = 1'b0;
        chk("R1 start wins", int'(cmd_pend), 1);
        idle(30);
        rd(7, 1'b1, v); chk("R2 start ignored while suspended", v, 0);

        idle(5);
        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule